// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is an 8-bit binary down-counter for a real-time-clock subsystem. Software writes a start value into the value register and picks one of four source rates in the control register: 4096 Hz, 64 Hz, 1 Hz or one tick per minute. The rates arrive as single-cycle strobes from a divider outside the block. While the timer is running, each strobe of the chosen rate lowers the count by one. When a strobe arrives with the count at 1, the counter reloads the software value and raises a sticky expiry flag.

The flag stays set until the status logic clears it with a one-cycle clear strobe. The interrupt condition has two modes. In level mode it follows the flag. In pulse mode it is high for one period of the selected source after each expiry.

Reads are combinational. Reading the value register returns the live count. The control register sits at address 0xE and the value register at 0xF. Both addresses are parameters.

Top module: `countdown_timer`

## Requirements
- R1: After reset the control register reads 0x03 (stopped, select 11), the value register reads 0, and `flag_o` and `irq_o` are 0.
- R2: In the control register, bit 7 is the run bit and bits 1:0 are the rate select. All other bits read as 0, and a write is read back on the next cycle.
- R3: A write to the value register sets both the reload value and the live count. A read of address 0xF returns the live count, and a read of any unused address returns 0.
- R4: While the timer is running with a non-zero reload value, each strobe on `src_tick_i[sel]` lowers the count by one. Select 00 picks bit 0 (4096 Hz), 01 picks bit 1 (64 Hz), 10 picks bit 2 (1 Hz) and 11 picks bit 3 (1/60 Hz). Strobes on the other bits are ignored.
- R5: A selected strobe that arrives while the count is 1 reloads the count with the software value and sets `flag_o`. Both take effect on the next cycle.
- R6: While the run bit is 0, the count holds regardless of strobes.
- R7: With a loaded value of 0, the count stays 0 and the flag is never set.
- R8: `flag_o` stays set until `flag_clr_i` is pulsed. An expiry in the same cycle as a clear leaves the flag set.
- R9: With `pulse_mode_i` = 0, `irq_o` equals `flag_o`.
- R10: With `pulse_mode_i` = 1, `irq_o` rises in the cycle after an expiry. It falls in the cycle after the next selected strobe, even while the flag remains set.
- R11: A value-register write in the same cycle as a selected strobe takes priority. The count becomes the written value and no decrement or expiry happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe for `addr_i` |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for `addr_i` |
| src_tick_i | input | 4 | Single-cycle strobes: bit 0 4096 Hz, bit 1 64 Hz, bit 2 1 Hz, bit 3 1/60 Hz |
| pulse_mode_i | input | 1 | 0 = interrupt follows the flag, 1 = pulsed interrupt |
| flag_clr_i | input | 1 | One-cycle clear of the expiry flag |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Timer interrupt condition |

## Verification
The hardest situations to reach are the collisions: an expiry in the same cycle as a flag clear, and a value-register write in the same cycle as a selected strobe. In a real system these events are seconds or minutes apart. The bench drives the divider strobes directly, so it can load a count of 1 and then raise the selected strobe, the clear and the write together on a single edge. A behavioural model is compared on every cycle. A long pseudo-random phase mixes rates, reload values, modes and clears, and the model catches any divergence along the way.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned NUM_SRC   = 1 << SEL_W;
   localparam int unsigned CTRL_RUN_BIT = 7;
   localparam logic [SEL_W-1:0] SEL_RESET = '1;

   typedef struct packed {
      logic             run;
      logic [SEL_W-1:0] sel;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_src_mux.sv
module tmr_src_mux #(
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned NUM_SRC = 1 << SEL_W
) (
   input  logic [NUM_SRC-1:0] tick_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               hit_o
);
   logic [NUM_SRC-1:0] match;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign match[i] = tick_i[i] && (sel_i == SEL_W'(i));
   end

   assign hit_o = |match;
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int unsigned COUNT_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               tick_i,
   input  logic               load_i,
   input  logic [COUNT_W-1:0] load_val_i,
   output logic [COUNT_W-1:0] count_o,
   output logic [COUNT_W-1:0] reload_o,
   output logic               expire_o
);
   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   logic [COUNT_W-1:0] cnt_q;
   logic [COUNT_W-1:0] rel_q;
   logic               armed;

   assign armed    = (rel_q != '0);
   assign expire_o = tick_i && !load_i && armed && (cnt_q == ONE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         rel_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         rel_q <= load_val_i;
      end else if (tick_i && armed) begin
         cnt_q <= (cnt_q == ONE) ? rel_q : cnt_q - ONE;
      end
   end

   assign count_o  = cnt_q;
   assign reload_o = rel_q;
endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen #(
   parameter bit HAS_PULSE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic expire_i,
   input  logic sel_tick_i,
   input  logic flag_clr_i,
   input  logic pulse_mode_i,
   output logic flag_o,
   output logic irq_o
);
   logic flag_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)         flag_q <= 1'b0;
      else if (expire_i)   flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   if (HAS_PULSE) begin : g_pulse
      logic pulse_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)         pulse_q <= 1'b0;
         else if (expire_i)   pulse_q <= 1'b1;
         else if (sel_tick_i) pulse_q <= 1'b0;
      end
      assign irq_o = pulse_mode_i ? pulse_q : flag_q;
   end else begin : g_level
      logic unused_in;
      assign unused_in = sel_tick_i ^ pulse_mode_i;
      assign irq_o = flag_q;
   end
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
   import tmr_pkg::*;
#(
   parameter int unsigned COUNT_W    = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 4'hE,
   parameter logic [ADDR_W-1:0] VALUE_ADDR = 4'hF,
   parameter bit HAS_PULSE = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                wr_en_i,
   input  logic [DATA_W-1:0]   wr_data_i,
   output logic [DATA_W-1:0]   rd_data_o,
   input  logic [NUM_SRC-1:0]  src_tick_i,
   input  logic                pulse_mode_i,
   input  logic                flag_clr_i,
   output logic                flag_o,
   output logic                irq_o
);
   initial begin
      assert (COUNT_W <= DATA_W) else $error("count wider than data bus");
      assert (CTRL_RUN_BIT < DATA_W && SEL_W < CTRL_RUN_BIT)
         else $error("control fields do not fit the data bus");
      assert (CTRL_ADDR != VALUE_ADDR) else $error("register addresses collide");
   end

   tmr_ctrl_t          ctrl_q;
   logic               wr_ctrl, wr_val;
   logic               sel_tick, run_tick, expire;
   logic [COUNT_W-1:0] cnt, reload;

   assign wr_ctrl = wr_en_i && (addr_i == CTRL_ADDR);
   assign wr_val  = wr_en_i && (addr_i == VALUE_ADDR);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_q.run <= 1'b0;
         ctrl_q.sel <= SEL_RESET;
      end else if (wr_ctrl) begin
         ctrl_q.run <= wr_data_i[CTRL_RUN_BIT];
         ctrl_q.sel <= wr_data_i[SEL_W-1:0];
      end
   end

   tmr_src_mux #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_mux (
      .tick_i (src_tick_i),
      .sel_i  (ctrl_q.sel),
      .hit_o  (sel_tick)
   );

   assign run_tick = sel_tick && ctrl_q.run;

   tmr_down_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (run_tick),
      .load_i     (wr_val),
      .load_val_i (wr_data_i[COUNT_W-1:0]),
      .count_o    (cnt),
      .reload_o   (reload),
      .expire_o   (expire)
   );

   tmr_irq_gen #(.HAS_PULSE(HAS_PULSE)) u_irq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .expire_i     (expire),
      .sel_tick_i   (sel_tick),
      .flag_clr_i   (flag_clr_i),
      .pulse_mode_i (pulse_mode_i),
      .flag_o       (flag_o),
      .irq_o        (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      if (addr_i == CTRL_ADDR) begin
         rd_data_o[CTRL_RUN_BIT] = ctrl_q.run;
         rd_data_o[SEL_W-1:0]    = ctrl_q.sel;
      end else if (addr_i == VALUE_ADDR) begin
         rd_data_o[COUNT_W-1:0]  = cnt;
      end
   end
endmodule

// File: rtl/tmr_checks.sv
module tmr_checks #(
   parameter int unsigned COUNT_W = 8,
   parameter int unsigned DATA_W  = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               run,
   input logic               sel_tick,
   input logic               wr_val,
   input logic [DATA_W-1:0]  wr_data,
   input logic [COUNT_W-1:0] cnt,
   input logic [COUNT_W-1:0] reload,
   input logic               flag,
   input logic               flag_clr,
   input logic               pulse_mode,
   input logic               irq
);
   a_r3_load_sets_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_val |=> (cnt == $past(wr_data[COUNT_W-1:0])) && (reload == cnt));

   a_r4_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && sel_tick && !wr_val && cnt > COUNT_W'(1))
      |=> cnt == $past(cnt) - COUNT_W'(1));

   a_r5_reload_and_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && sel_tick && !wr_val && cnt == COUNT_W'(1) && reload != '0)
      |=> (cnt == $past(reload)) && flag);

   a_r6_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !wr_val) |=> $stable(cnt));

   a_r7_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reload == '0) |-> (cnt == '0));

   a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag && !flag_clr) |=> flag);

   a_r10_pulse_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_mode && $past(pulse_mode) && $rose(irq)) |-> flag);
endmodule

bind countdown_timer tmr_checks #(.COUNT_W(COUNT_W), .DATA_W(DATA_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .run        (ctrl_q.run),
   .sel_tick   (sel_tick),
   .wr_val     (wr_val),
   .wr_data    (wr_data_i),
   .cnt        (cnt),
   .reload     (reload),
   .flag       (flag_o),
   .flag_clr   (flag_clr_i),
   .pulse_mode (pulse_mode_i),
   .irq        (irq_o)
);

// File: tb/sim_countdown_timer.sv
module sim_countdown_timer;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] A_CTRL = 4'hE;
   localparam logic [3:0] A_VAL  = 4'hF;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = A_VAL;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [3:0] ticks = '0;
   logic       pm = 1'b0;
   logic       clr = 1'b0;
   logic       flag, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   countdown_timer u0 (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_data_o(rd_data), .src_tick_i(ticks),
      .pulse_mode_i(pm), .flag_clr_i(clr), .flag_o(flag), .irq_o(irq)
   );

   // behavioural reference model
   bit m_run; int m_sel; int m_cnt; int m_rel; bit m_flag; bit m_pulse;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_sel = 3; m_cnt = 0; m_rel = 0; m_flag = 0; m_pulse = 0;
      end else begin
         bit hit, wv, exp_now;
         hit = ticks[m_sel];
         wv = wr_en && addr == A_VAL;
         exp_now = m_run && hit && !wv && m_rel != 0 && m_cnt == 1;
         if (wv) begin m_cnt = wr_data; m_rel = wr_data; end
         else if (m_run && hit && m_rel != 0) m_cnt = (m_cnt == 1) ? m_rel : m_cnt - 1;
         if (exp_now) m_flag = 1; else if (clr) m_flag = 0;
         if (exp_now) m_pulse = 1; else if (hit) m_pulse = 0;
         if (wr_en && addr == A_CTRL) begin m_run = wr_data[7]; m_sel = wr_data[1:0]; end
      end
   end

   function automatic int m_read(input logic [3:0] a);
      if (a == A_CTRL) return (m_run ? 128 : 0) + m_sel;
      if (a == A_VAL) return m_cnt;
      return 0;
   endfunction

   task automatic chk(input string t, input string what, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", t, what, got, exp);
      end
   endtask

   task automatic compare_all();
      chk(tag, "flag_o", flag, m_flag);
      chk(tag, "irq_o", irq, pm ? m_pulse : m_flag);
      chk(tag, "rd_data_o", rd_data, m_read(addr));
   endtask

   task automatic cyc(input logic [3:0] tk, input logic w, input logic [3:0] a,
                      input logic [7:0] d, input logic c);
      ticks = tk; wr_en = w; addr = a; wr_data = d; clr = c;
      @(posedge clk);
      @(negedge clk);
      compare_all();
      ticks = '0; wr_en = 0; clr = 0; addr = A_VAL;
   endtask

   task automatic peek(input logic [3:0] a, output int v);
      addr = a; #1; v = rd_data;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      int lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      tag = "R1";
      peek(A_CTRL, v); chk("R1", "ctrl reset", v, 8'h03);
      peek(A_VAL, v);  chk("R1", "count reset", v, 0);
      chk("R1", "flag reset", flag, 0);
      chk("R1", "irq reset", irq, 0);
      compare_all();

      // R2 control fields
      tag = "R2";
      cyc(0, 1, A_CTRL, 8'hFF, 0);
      peek(A_CTRL, v); chk("R2", "ctrl readback", v, 8'h83);
      cyc(0, 1, A_CTRL, 8'h80, 0);
      peek(A_CTRL, v); chk("R2", "ctrl run sel00", v, 8'h80);

      // R3 load and live read
      tag = "R3";
      cyc(0, 1, A_VAL, 8'd5, 0);
      peek(A_VAL, v); chk("R3", "loaded count", v, 5);
      peek(4'h3, v);  chk("R3", "unused address", v, 0);

      // R4 selection and decrement
      tag = "R4";
      cyc(4'b0001, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R4", "sel00 step", v, 4);
      cyc(4'b1110, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R4", "other strobes ignored", v, 4);
      cyc(4'b0001, 0, A_VAL, 0, 0);
      cyc(4'b0001, 0, A_VAL, 0, 0);
      cyc(0, 1, A_CTRL, 8'h81, 0);
      cyc(4'b0001, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R4", "sel01 ignores bit0", v, 2);
      cyc(4'b0010, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R4", "sel01 step", v, 1);

      // R5 expiry reload
      tag = "R5";
      cyc(4'b0010, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R5", "reload after expiry", v, 5);
      chk("R5", "flag set", flag, 1);

      // R8 sticky and clear
      tag = "R8";
      cyc(0, 0, A_VAL, 0, 0); cyc(0, 0, A_VAL, 0, 0);
      chk("R8", "flag sticky", flag, 1);
      cyc(0, 0, A_VAL, 0, 1);
      chk("R8", "flag cleared", flag, 0);

      // R10 pulse mode
      tag = "R10";
      pm = 1;
      cyc(0, 1, A_CTRL, 8'h82, 0);
      cyc(0, 1, A_VAL, 8'd2, 0);
      cyc(4'b0100, 0, A_VAL, 0, 0);
      chk("R10", "no pulse before expiry", irq, 0);
      cyc(4'b0100, 0, A_VAL, 0, 0);
      chk("R10", "pulse rises", irq, 1);
      cyc(0, 0, A_VAL, 0, 0); cyc(4'b1011, 0, A_VAL, 0, 0);
      chk("R10", "pulse holds for period", irq, 1);
      cyc(4'b0100, 0, A_VAL, 0, 0);
      chk("R10", "pulse falls", irq, 0);
      chk("R10", "flag still set", flag, 1);

      // R9 level mode
      tag = "R9";
      pm = 0; #1;
      chk("R9", "irq follows flag high", irq, 1);
      cyc(0, 0, A_VAL, 0, 1);
      chk("R9", "irq follows flag low", irq, 0);

      // R8 set wins over clear, sel11 path
      tag = "R8";
      cyc(0, 1, A_CTRL, 8'h83, 0);
      cyc(0, 1, A_VAL, 8'd1, 0);
      cyc(4'b1000, 0, A_VAL, 0, 1);
      chk("R8", "expiry beats clear", flag, 1);
      cyc(0, 0, A_VAL, 0, 1);

      // R6 stopped
      tag = "R6";
      cyc(0, 1, A_CTRL, 8'h03, 0);
      cyc(0, 1, A_VAL, 8'd7, 0);
      cyc(4'b1111, 0, A_VAL, 0, 0); cyc(4'b1111, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R6", "count holds when stopped", v, 7);

      // R7 zero load
      tag = "R7";
      cyc(0, 1, A_CTRL, 8'h80, 0);
      cyc(0, 1, A_VAL, 8'd0, 0);
      for (int i = 0; i < 4; i++) cyc(4'b0001, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R7", "zero stays zero", v, 0);
      chk("R7", "no flag from zero", flag, 0);

      // R11 write beats strobe
      tag = "R11";
      cyc(0, 1, A_VAL, 8'd1, 0);
      cyc(4'b0001, 1, A_VAL, 8'd9, 0);
      peek(A_VAL, v); chk("R11", "write wins", v, 9);
      chk("R11", "no expiry on write", flag, 0);
      cyc(4'b0001, 0, A_VAL, 0, 0);
      peek(A_VAL, v); chk("R11", "counts after write", v, 8);

      // R4 mixed pseudo-random traffic
      tag = "R4";
      lfsr = 32'h1ACE5;
      for (int i = 0; i < 3000; i++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
         pm = lfsr[20];
         if (lfsr[9:4] == 0)
            cyc(0, 1, A_CTRL, {lfsr[30], 5'b0, lfsr[12:11]}, 0);
         else if (lfsr[9:4] == 1)
            cyc(lfsr[3:0], 1, A_VAL, {5'b0, lfsr[15:13]}, 0);
         else
            cyc(lfsr[3:0], 0, (lfsr[17] ? A_CTRL : A_VAL), 0, lfsr[27:24] == 0);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule